// File: doc/BRIEF.md
# Vector Element Rotate-and-Merge Unit

This unit performs a masked rotate-and-merge on a 128-bit vector in a single registered pipeline stage. The vector is divided into equal lanes whose width is chosen by a size code. Each source lane is rotated left circularly by an immediate count, and the rotated bits replace the destination bits wherever the mask lane holds a one. Where the mask holds a zero, the original destination bits pass through.

The old destination contents arrive as an ordinary operand. Each lane is handled on its own, and every lane uses the same count, which is reduced modulo the lane width. Any size code outside the four legal values produces no merged result. The unit raises an exception flag instead and returns the old destination unchanged. All outputs are registered and appear one clock after an accepted input.

Top module: `vrot_merge`

## Requirements
- R1: Synchronous active-high reset clears `done` and `bad_size` on the next clock edge.
- R2: An input accepted while `start` is high produces `done` high exactly one clock later. `done` is low in every cycle that does not follow an accepted input.
- R3: Size code 0 selects 16 lanes of 8 bits. Each lane becomes (dst AND NOT msk) OR (rotl(src, cnt mod 8) AND msk).
- R4: Size code 1 selects 8 lanes of 16 bits and uses the same merge, with the count reduced mod 16.
- R5: Size code 2 selects 4 lanes of 32 bits and uses the same merge, with the count reduced mod 32.
- R6: Size code 3 selects 2 lanes of 64 bits and uses the same merge, with the count reduced mod 64.
- R7: Lane 0 occupies bits 127 down to 128-W. Rotated bits never cross a lane boundary.
- R8: Size codes 4 to 15 set `bad_size` one clock later, and `res` equals the `dst` operand unchanged.
- R9: A legal size code clears `bad_size` on the completing cycle.
- R10: A count of zero gives a plain bitwise select: `res` = (dst AND NOT msk) OR (src AND msk).
- R11: The outputs `res` and `bad_size` hold their values in every cycle where `start` was low on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | operands valid this cycle |
| size | input | 4 | lane size code (0:8, 1:16, 2:32, 3:64 bits) |
| cnt | input | 8 | immediate rotate count |
| dst | input | 128 | old destination contents |
| src | input | 128 | source to rotate |
| msk | input | 128 | merge mask |
| done | output | 1 | result valid |
| res | output | 128 | merged result |
| bad_size | output | 1 | illegal size code exception |

## Verification
The embedded assertions check the timing on every cycle. They confirm that `done` follows an accepted input by exactly one cycle, that an illegal code raises `bad_size` and returns the old destination, and that the outputs stay stable while idle. They also check that bits the mask leaves at zero always come from `dst`. The bit-level result of the rotation for each lane size, the modulo reduction of the count, and the lane ordering can only be shown by the bench. It sweeps every count from 0 to 255 for every size code against a merge computed arithmetically.

// File: rtl/vrot_merge.sv
module vrot_merge #(
  parameter int VW = 128,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [3:0]    size,
  input  logic [CW-1:0] cnt,
  input  logic [VW-1:0] dst,
  input  logic [VW-1:0] src,
  input  logic [VW-1:0] msk,
  output logic          done,
  output logic [VW-1:0] res,
  output logic          bad_size
);

  localparam int N8  = VW / 8;
  localparam int N16 = VW / 16;
  localparam int N32 = VW / 32;
  localparam int N64 = VW / 64;

  logic [VW-1:0] rot8, rot16, rot32, rot64, rot_sel;
  logic          legal;

  assign legal = (size < 4'd4);

  genvar g;
  generate
    for (g = 0; g < N8; g++) begin : g_l8
      logic [7:0] e;
      assign e = src[VW-1-8*g -: 8];
      assign rot8[VW-1-8*g -: 8] = 8'((e << cnt[2:0]) | (e >> (4'd8 - {1'b0, cnt[2:0]})));
    end
    for (g = 0; g < N16; g++) begin : g_l16
      logic [15:0] e;
      assign e = src[VW-1-16*g -: 16];
      assign rot16[VW-1-16*g -: 16] = 16'((e << cnt[3:0]) | (e >> (5'd16 - {1'b0, cnt[3:0]})));
    end
    for (g = 0; g < N32; g++) begin : g_l32
      logic [31:0] e;
      assign e = src[VW-1-32*g -: 32];
      assign rot32[VW-1-32*g -: 32] = 32'((e << cnt[4:0]) | (e >> (6'd32 - {1'b0, cnt[4:0]})));
    end
    for (g = 0; g < N64; g++) begin : g_l64
      logic [63:0] e;
      assign e = src[VW-1-64*g -: 64];
      assign rot64[VW-1-64*g -: 64] = 64'((e << cnt[5:0]) | (e >> (7'd64 - {1'b0, cnt[5:0]})));
    end
  endgenerate

  always_comb begin
    case (size[1:0])
      2'd0:    rot_sel = rot8;
      2'd1:    rot_sel = rot16;
      2'd2:    rot_sel = rot32;
      default: rot_sel = rot64;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      bad_size <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        bad_size <= !legal;
        res      <= legal ? ((dst & ~msk) | (rot_sel & msk)) : dst;
      end
    end
  end

  assert_done_follows_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);
  assert_bad_passthru_R8: assert property (@(posedge clk) disable iff (rst)
    (start && size >= 4'd4) |=> (bad_size && res == $past(dst)));
  assert_good_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (start && size < 4'd4) |=> !bad_size);
  assert_unmasked_keep_R3: assert property (@(posedge clk) disable iff (rst)
    start |=> ((res & ~$past(msk)) == ($past(dst) & ~$past(msk))));
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!start && done) |=> ($stable(res) && $stable(bad_size)));

endmodule

// File: tb/test_vrot_merge.sv
module test_vrot_merge;
  logic clk = 0, rst = 1, start = 0;
  logic [3:0] size = 0;
  logic [7:0] cnt = 0;
  logic [127:0] dst = 0, src = 0, msk = 0;
  logic done, bad_size;
  logic [127:0] res;
  int nchk = 0, nbad = 0;

  always #5 clk = ~clk;

  vrot_merge i_vrot_merge (.clk, .rst, .start, .size, .cnt, .dst, .src, .msk,
                           .done, .res, .bad_size);

  function automatic logic [127:0] model(int sz, int c, logic [127:0] d, s, m);
    logic [127:0] r;
    int w, k;
    if (sz > 3) return d;
    w = 8 << sz; k = c % w;
    for (int l = 0; l < 128 / w; l++) begin
      for (int b = 0; b < w; b++) begin
        int lsb = 128 - w * (l + 1);
        int srcb = (b - k + w) % w;
        r[lsb + b] = m[lsb + b] ? s[lsb + srcb] : d[lsb + b];
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [127:0] act, exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(int sz, int c, logic [127:0] d, s, m, string tag);
    @(negedge clk);
    start = 1; size = 4'(sz); cnt = 8'(c); dst = d; src = s; msk = m;
    @(negedge clk);
    start = 0;
    check({tag, " done R2"}, {127'b0, done}, 128'd1);
    check({tag, " exc R8 R9"}, {127'b0, bad_size}, {127'b0, sz > 3});
    check({tag, " res"}, res, model(sz, c, d, s, m));
  endtask

  initial begin
    #2000000;
    nbad++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    logic [127:0] d, s, m;
    repeat (2) @(negedge clk);
    rst = 0;
    check("reset R1", {126'b0, done, bad_size}, 128'd0);
    for (int sz = 0; sz < 16; sz++) begin
      for (int c = 0; c < 256; c++) begin
        d = {$urandom, $urandom, $urandom, $urandom};
        s = {$urandom, $urandom, $urandom, $urandom};
        m = {$urandom, $urandom, $urandom, $urandom};
        case (sz)
          0: apply(sz, c, d, s, m, "R3");
          1: apply(sz, c, d, s, m, "R4");
          2: apply(sz, c, d, s, m, "R5");
          3: apply(sz, c, d, s, m, "R6");
          default: apply(sz, c, d, s, m, "R8");
        endcase
      end
    end
    for (int sz = 0; sz < 4; sz++) begin
      apply(sz, 1, 128'h0, 128'h8000_0000_0000_0000_0000_0000_0000_0000, '1, "R7 lane0 wrap");
      apply(sz, 0, {4{32'hA5A5_5A5A}}, {4{32'h1234_5678}}, {4{32'h0F0F_F0F0}}, "R10");
    end
    apply(0, 3, 128'h0, '1, 128'h0, "R10 mask0");
    @(negedge clk); @(negedge clk);
    check("idle done R2", {127'b0, done}, 128'd0);
    check("idle hold R11", res, model(0, 3, 128'h0, '1, 128'h0));
    apply(5, 2, 128'h1, 128'h2, '1, "R8");
    apply(2, 2, 128'h1, 128'h2, '1, "R9");
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    check("reset again R1", {126'b0, done, bad_size}, 128'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule